// File: doc/BRIEF.md
# AXI Burst Address Splitter

This block sits on an AXI-style address command path and turns one burst command into a train of single-transfer commands. A command arrives on a valid/ready input stream with a start address, a burst kind, a beat-count field and a transfer-size field. The block then issues one command per beat on a valid/ready output stream. Each output command carries the byte address of that beat, with a flag on the final beat. The identifier, the kind, the length and the size fields are copied through unchanged.

Three address patterns are generated. A fixed burst repeats its start address. An incrementing burst steps by the transfer size, using plain modular arithmetic over the full address width. A wrapping burst steps the same way but folds back to the bottom of an aligned window whose size is the beat count times the transfer size. A new command is taken only when the block is idle, or in the same cycle as the final beat of the current burst leaves the block. Either side may stall at any time without losing or repeating beats.

Top module: `axi_burst_splitter`

## Requirements
- R1: A command whose length field is L produces exactly L+1 output beats. `out_last` is 1 on the final beat and 0 on every earlier beat.
- R2: For kind code 0 (fixed), and for the unused code 3, every beat carries the start address unchanged.
- R3: For kind code 1 (incrementing), beat i carries start + i * 2^size modulo 2^ADDR_W, where size is the transfer-size field. Carries past the top address bit are dropped.
- R4: For kind code 2 (wrapping), with beat count N = L+1 in {2,4,8,16} and a start aligned to 2^size, the window span is S = N * 2^size and the base is start rounded down to a multiple of S. Beat i carries base + ((start - base + i * 2^size) mod S).
- R5: `out_id`, `out_kind`, `out_len` and `out_size` equal the accepted command's fields on every beat of that burst.
- R6: `in_ready` is 1 when no burst is in progress. While a burst is in progress, it is 1 only in a cycle where the final beat is being transferred (`out_valid`, `out_ready` and `out_last` all 1).
- R7: While `out_valid` is 1 and `out_ready` is 0, the output command is held: on the next cycle `out_valid` stays 1 and the address, identifier and last flag are unchanged.
- R8: During reset and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Burst command offered |
| in_ready | output | 1 | Burst command taken this cycle when in_valid is 1 |
| in_addr | input | ADDR_W | Start byte address |
| in_kind | input | 2 | Burst kind: 0 fixed, 1 incrementing, 2 wrapping |
| in_len | input | LEN_W | Beat count minus one |
| in_size | input | SIZE_W | Log2 of bytes per transfer |
| in_id | input | ID_W | Transaction identifier |
| out_valid | output | 1 | Single-beat command offered |
| out_ready | input | 1 | Downstream accepts the beat |
| out_addr | output | ADDR_W | Byte address of this beat |
| out_kind | output | 2 | Copied burst kind |
| out_len | output | LEN_W | Copied length field |
| out_size | output | SIZE_W | Copied size field |
| out_id | output | ID_W | Copied identifier |
| out_last | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with its defaults: a 32-bit address, an 8-bit length field, a 3-bit size field and a 4-bit identifier. With the 8-bit length field, a 256-beat incrementing burst can be sent, so the beat counter reaches its top value. With the 32-bit address, an incrementing burst that starts just below 2^32 shows the carry being dropped. The 3-bit size field allows transfers of up to 128 bytes. With these, wrapping windows from 2 bytes up to 2 KB are generated and checked against their modulo formula, under random stalls on both streams.

// File: rtl/burst_split_pkg.sv
`timescale 1ns/1ps
package burst_split_pkg;
   typedef enum logic [1:0] {
      BK_FIXED = 2'd0,
      BK_INCR  = 2'd1,
      BK_WRAP  = 2'd2,
      BK_RSVD  = 2'd3
   } burst_kind_e;
endpackage

// File: rtl/bsplit_beat_ctr.sv
`timescale 1ns/1ps
module bsplit_beat_ctr #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [LEN_W-1:0] len,
   output logic [LEN_W-1:0] idx,
   output logic             last
);
   always_ff @(posedge clk) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= '0;
      else if (step) idx <= idx + LEN_W'(1);
   end

   assign last = (idx == len);
endmodule

// File: rtl/bsplit_addr_gen.sv
`timescale 1ns/1ps
module bsplit_addr_gen
   import burst_split_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 8,
   parameter int SIZE_W  = 3,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] start,
   input  logic [LEN_W-1:0]  idx,
   input  logic [LEN_W-1:0]  len,
   input  logic [SIZE_W-1:0] size,
   input  logic [1:0]        kind,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] stride_off;
   logic [ADDR_W-1:0] linear;
   logic [ADDR_W-1:0] wrapped;

   assign stride_off = ADDR_W'(idx) << size;
   assign linear     = start + stride_off;

   generate
      if (WRAP_EN) begin : g_wrap
         logic [ADDR_W-1:0] span;
         logic [ADDR_W-1:0] win_mask;
         assign span     = (ADDR_W'(len) + ADDR_W'(1)) << size;
         assign win_mask = span - ADDR_W'(1);
         assign wrapped  = (start & ~win_mask) | (linear & win_mask);
      end else begin : g_nowrap
         assign wrapped = linear;
      end
   endgenerate

   always_comb begin
      case (burst_kind_e'(kind))
         BK_INCR: addr = linear;
         BK_WRAP: addr = wrapped;
         default: addr = start;
      endcase
   end
endmodule

// File: rtl/axi_burst_splitter.sv
`timescale 1ns/1ps
module axi_burst_splitter #(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 8,
   parameter int SIZE_W  = 3,
   parameter int ID_W    = 4,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [1:0]        in_kind,
   input  logic [LEN_W-1:0]  in_len,
   input  logic [SIZE_W-1:0] in_size,
   input  logic [ID_W-1:0]   in_id,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [1:0]        out_kind,
   output logic [LEN_W-1:0]  out_len,
   output logic [SIZE_W-1:0] out_size,
   output logic [ID_W-1:0]   out_id,
   output logic              out_last
);
   localparam int MAX_BEATS = 1 << LEN_W;

   generate
      if (ADDR_W < 8)                 begin : g_bad_addr $error("ADDR_W must be at least 8"); end
      if (LEN_W < 1 || LEN_W > 8)     begin : g_bad_len  $error("LEN_W must be 1..8"); end
      if (SIZE_W < 1 || SIZE_W > 3)   begin : g_bad_size $error("SIZE_W must be 1..3"); end
      if (ID_W < 1)                   begin : g_bad_id   $error("ID_W must be at least 1"); end
      if (MAX_BEATS * 128 > (64'd1 << ADDR_W)) begin : g_bad_span
         $error("ADDR_W too narrow for the largest burst span");
      end
   endgenerate

   logic              busy;
   logic [ADDR_W-1:0] r_start;
   logic [1:0]        r_kind;
   logic [LEN_W-1:0]  r_len;
   logic [SIZE_W-1:0] r_size;
   logic [ID_W-1:0]   r_id;
   logic [LEN_W-1:0]  beat_idx;
   logic              beat_last;
   logic              take_cmd;
   logic              beat_go;
   logic              burst_done;

   assign beat_go    = busy & out_ready;
   assign burst_done = beat_go & beat_last;
   assign in_ready   = ~busy | burst_done;
   assign take_cmd   = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         r_start <= '0;
         r_kind  <= '0;
         r_len   <= '0;
         r_size  <= '0;
         r_id    <= '0;
      end else if (take_cmd) begin
         busy    <= 1'b1;
         r_start <= in_addr;
         r_kind  <= in_kind;
         r_len   <= in_len;
         r_size  <= in_size;
         r_id    <= in_id;
      end else if (burst_done) begin
         busy    <= 1'b0;
      end
   end

   bsplit_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take_cmd),
      .step  (beat_go),
      .len   (r_len),
      .idx   (beat_idx),
      .last  (beat_last)
   );

   bsplit_addr_gen #(
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W),
      .SIZE_W  (SIZE_W),
      .WRAP_EN (WRAP_EN)
   ) u_addr (
      .start (r_start),
      .idx   (beat_idx),
      .len   (r_len),
      .size  (r_size),
      .kind  (r_kind),
      .addr  (out_addr)
   );

   assign out_valid = busy;
   assign out_kind  = r_kind;
   assign out_len   = r_len;
   assign out_size  = r_size;
   assign out_id    = r_id;
   assign out_last  = beat_last;
endmodule

// File: rtl/bsplit_checker.sv
`timescale 1ns/1ps
module bsplit_checker #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int SIZE_W = 3,
   parameter int ID_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_last,
   input logic [ADDR_W-1:0] out_addr,
   input logic [1:0]        out_kind,
   input logic [LEN_W-1:0]  out_len,
   input logic [SIZE_W-1:0] out_size,
   input logic [ID_W-1:0]   out_id
);
   logic beat_move;
   assign beat_move = out_valid & out_ready;

   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_id) && $stable(out_last)));

   a_r6_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && in_ready) |-> (out_ready && out_last));

   a_r2_fixed_same: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_move && !out_last && out_kind == 2'd0) |=> (out_addr == $past(out_addr)));

   a_r3_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_move && !out_last && out_kind == 2'd1)
      |=> (out_addr == $past(out_addr) + (ADDR_W'(1) << $past(out_size))));

   a_r5_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_move && !out_last)
      |=> (out_valid && $stable(out_id) && $stable(out_len) && $stable(out_kind) && $stable(out_size)));

   a_r4_wrap_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 2'd2) |-> ((out_addr & ((ADDR_W'(1) << out_size) - ADDR_W'(1))) == '0));

   a_r8_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

bind axi_burst_splitter bsplit_checker #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W),
   .SIZE_W (SIZE_W),
   .ID_W   (ID_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_last  (out_last),
   .out_addr  (out_addr),
   .out_kind  (out_kind),
   .out_len   (out_len),
   .out_size  (out_size),
   .out_id    (out_id)
);

// File: tb/axi_burst_splitter_tb_top.sv
`timescale 1ns/1ps
module axi_burst_splitter_tb_top;
   localparam int AW = 32;
   localparam int LW = 8;
   localparam int SW = 3;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [AW-1:0] in_addr = '0;
   logic [1:0]    in_kind = '0;
   logic [LW-1:0] in_len = '0;
   logic [SW-1:0] in_size = '0;
   logic [IW-1:0] in_id = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [AW-1:0] out_addr;
   logic [1:0]    out_kind;
   logic [LW-1:0] out_len;
   logic [SW-1:0] out_size;
   logic [IW-1:0] out_id;
   logic          out_last;

   always #2 clk = ~clk;

   axi_burst_splitter dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_kind(in_kind),
      .in_len(in_len), .in_size(in_size), .in_id(in_id),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_kind(out_kind),
      .out_len(out_len), .out_size(out_size), .out_id(out_id), .out_last(out_last)
   );

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [IW-1:0] id;
      logic [1:0]    kind;
      logic [LW-1:0] len;
      logic [SW-1:0] size;
      logic          last;
   } beat_t;

   beat_t exp_q[$];
   int    n_checks = 0;
   int    n_fails  = 0;
   int    beats_pushed = 0;
   int    beats_seen = 0;
   int    rdy_pct = 100;
   bit    run_done = 1'b0;
   bit    consumer_on = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!run_done) begin
         run_done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   function automatic logic [AW-1:0] ref_addr(input logic [1:0] kind, input logic [AW-1:0] start,
                                              input int len, input int size, input int i);
      longint unsigned sz, span, base, off;
      sz = longint'(1) << size;
      case (kind)
         2'd1: return AW'(longint'(start) + longint'(i) * sz);
         2'd2: begin
            span = longint'(len + 1) * sz;
            base = longint'(start) - (longint'(start) % span);
            off  = (longint'(start) - base + longint'(i) * sz) % span;
            return AW'(base + off);
         end
         default: return start;
      endcase
   endfunction

   task automatic send(input logic [1:0] kind, input logic [AW-1:0] start,
                       input int len, input int size, input logic [IW-1:0] id);
      @(negedge clk);
      in_addr = start; in_kind = kind; in_len = LW'(len); in_size = SW'(size); in_id = id;
      in_valid = 1'b1;
      forever begin
         #1;
         if (in_ready) break;
         @(negedge clk);
      end
      for (int i = 0; i <= len; i++) begin
         beat_t b;
         b.addr = ref_addr(kind, start, len, size, i);
         b.id = id; b.kind = kind; b.len = LW'(len); b.size = SW'(size);
         b.last = (i == len);
         exp_q.push_back(b);
         beats_pushed++;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Consumer: random ready, per-beat compare, stall and ready-gate checks
   initial begin
      bit            prev_stall = 1'b0;
      logic [AW-1:0] prev_addr = '0;
      logic [IW-1:0] prev_id = '0;
      logic          prev_last = 1'b0;
      wait (consumer_on);
      forever begin
         @(negedge clk);
         out_ready = (($urandom % 100) < rdy_pct);
         #1;
         if (prev_stall) begin
            // R7: command held through the stall
            check(out_valid && out_addr == prev_addr && out_id == prev_id && out_last == prev_last,
                  "R7", out_addr, prev_addr);
         end
         if (!out_valid) begin
            check(in_ready == 1'b1, "R6 idle", in_ready, 1);
         end else if (exp_q.size() == 0) begin
            check(1'b0, "R1 extra beat", out_addr, 0);
         end else begin
            beat_t e;
            e = exp_q[0];
            check(in_ready == (out_ready && e.last), "R6 busy", in_ready, out_ready && e.last);
            if (out_ready) begin
               void'(exp_q.pop_front());
               beats_seen++;
               case (e.kind)
                  2'd1:    check(out_addr == e.addr, "R3 incr addr", out_addr, e.addr);
                  2'd2:    check(out_addr == e.addr, "R4 wrap addr", out_addr, e.addr);
                  default: check(out_addr == e.addr, "R2 fixed addr", out_addr, e.addr);
               endcase
               check(out_last == e.last, "R1 last flag", out_last, e.last);
               check(out_id == e.id && out_kind == e.kind && out_len == e.len && out_size == e.size,
                     "R5 fields", {out_id, out_kind, out_len, out_size}, {e.id, e.kind, e.len, e.size});
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_addr = out_addr; prev_id = out_id; prev_last = out_last;
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      #1;
      check(out_valid == 1'b0 && in_ready == 1'b1, "R8 in reset", {out_valid, in_ready}, 2'b01);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(out_valid == 1'b0 && in_ready == 1'b1, "R8 after reset", {out_valid, in_ready}, 2'b01);
      consumer_on = 1'b1;

      // Directed corner cases
      rdy_pct = 100;
      send(2'd2, 32'h0000_0004, 3, 1, 4'h1);     // R4: 4,6,0,2
      send(2'd2, 32'h8000_0160, 3, 4, 4'h2);     // R4: 160,170,140,150
      send(2'd1, 32'hFFFF_FFF8, 3, 2, 4'h3);     // R3: carry dropped past top
      send(2'd0, 32'h1234_5678, 0, 2, 4'h4);     // R1: single beat
      rdy_pct = 50;
      send(2'd1, 32'h0000_1000, 255, 2, 4'h5);   // R1: 256 beats
      send(2'd2, 32'h0000_0A7F, 15, 0, 4'h6);    // R4: 16 one-byte beats
      send(2'd2, 32'h0000_7F80, 15, 7, 4'h7);    // R4: 2 KB window
      send(2'd3, 32'hDEAD_BEE0, 2, 2, 4'h8);     // R2: reserved code holds address
      send(2'd0, 32'hCAFE_0000, 5, 3, 4'h9);     // R2: fixed repeat

      // Constrained random bursts
      for (int n = 0; n < 400; n++) begin
         logic [1:0]    k;
         logic [AW-1:0] a;
         int            l, s, g;
         rdy_pct = (n < 200) ? 60 : 25;
         k = 2'($urandom % 3);
         s = $urandom % 8;
         a = $urandom;
         if (k == 2'd2) begin
            l = (2 << ($urandom % 4)) - 1;
            a = a & ~((AW'(1) << s) - AW'(1));
         end else begin
            l = $urandom % 20;
         end
         send(k, a, l, s, IW'($urandom));
         g = $urandom % 3;
         repeat (g) @(negedge clk);
      end

      wait (exp_q.size() == 0);
      repeat (4) @(negedge clk);
      #1;
      check(beats_seen == beats_pushed, "R1 beat total", beats_seen, beats_pushed);
      check(out_valid == 1'b0, "R1 no trailing beat", out_valid, 0);
      finish_run();
   end
endmodule